// File: doc/BRIEF.md
# Bus Bridge Address Window Translator

This block sits in a host-to-PCI bridge and holds four translation windows, one for each child address space: memory, I/O, configuration and special. Each window records where it sits on the parent bus (parent base and parent space id), where it lands on the child bus (child base), and how many bytes it spans. A window counts as in use when its size is nonzero. Windows are loaded through a configuration port that checks every write. Translation stays off until an enable request arrives while at least one window is in use.

Outbound requests from the host carry an address and a byte count. The lowest-numbered in-use window that holds the whole access claims it. The block returns the child address, the slot id and that window's parent space id. When no window claims the access, the block reports a miss and a transfer of zero bytes. Inbound DMA requests from the child bus must name the memory space. A request whose start or end point falls inside the memory window's child range is refused, so it never loops back onto the bridge's own bus. Every other request is forwarded to the parent bus with its address unchanged.

A sticky error code records the first fault until software clears it. Each response appears one clock after its request.

Top module: `bridge_xlat`

## Requirements
- R1: There are four window slots, selected by a 2-bit code: 0 memory, 1 I/O, 2 configuration, 3 special. The configuration port carries a 3-bit slot field. An accepted write to a free slot 0..3 loads its parent base, parent space id, child base and size.
- R2: A configuration write whose slot field is 4..7 changes no window and raises error code 1.
- R3: A configuration write to a slot whose size is already nonzero leaves that slot unchanged and raises error code 2.
- R4: A clear sets the size of every slot to zero and turns translation off. While clear is high, cfg_ready is low and any configuration write in that cycle is ignored.
- R5: An enable request made while no slot is in use, judged on the table as it stood before that cycle, raises error code 3 and leaves translation off. Otherwise translation turns on. Translation is off after reset.
- R6: With translation on, an outbound request is claimed by the lowest-numbered in-use slot for which addr >= parent base and addr + nbytes <= parent base + size. The result appears on the cycle after the request.
- R7: A claimed request returns child address addr - parent base + child base (modulo 2^32), together with the claiming slot id and that slot's parent space id. The byte count returned equals the requested count.
- R8: An unclaimed request returns hit low with zero count, address and ids. This includes any request where addr + nbytes exceeds 2^32.
- R9: An inbound DMA whose space code is not 0 (memory) is neither forwarded nor refused, and raises error code 4.
- R10: An inbound memory DMA is refused when addr, or addr + nbytes, lies within [child base, child base + size] of slot 0. Both bounds are inclusive.
- R11: An inbound memory DMA that is not refused is forwarded one cycle later with its address unchanged and slot 0's parent space id.
- R12: The error code keeps its first nonzero value until err_clr. When a clear and a new error fall in the same cycle, the new error is recorded. Among errors raised in the same cycle, configuration errors win over the enable error, and the enable error wins over the DMA error.
- R13: An outbound or inbound request in the same cycle as a configuration write is judged against the table as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Write accepted this cycle (low during clear) |
| cfg_clear | input | 1 | Zero all window sizes and turn translation off |
| cfg_slot | input | 3 | Target slot; 0..3 valid |
| cfg_pbase | input | 32 | Window base on the parent bus |
| cfg_pspace | input | 4 | Parent space id |
| cfg_cbase | input | 32 | Window base on the child bus |
| cfg_size | input | 32 | Window size in bytes |
| en_req | input | 1 | Request to turn translation on |
| enabled | output | 1 | Translation is on |
| ob_valid | input | 1 | Outbound request |
| ob_addr | input | 32 | Outbound parent address |
| ob_nbytes | input | NBW | Outbound byte count |
| ob_rsp_valid | output | 1 | Outbound result valid |
| ob_hit | output | 1 | A window claimed the request |
| ob_slot | output | 2 | Claiming slot id |
| ob_pspace | output | 4 | Parent space id of the claiming slot |
| ob_caddr | output | 32 | Translated child address |
| ob_count | output | NBW | Bytes transferred (0 on miss) |
| dma_valid | input | 1 | Inbound DMA request |
| dma_space | input | 2 | Inbound space code |
| dma_addr | input | 32 | Inbound address |
| dma_nbytes | input | NBW | Inbound byte count |
| dma_rsp_valid | output | 1 | Inbound result valid |
| dma_fwd | output | 1 | Forwarded to parent |
| dma_reject | output | 1 | Refused: touches own memory window |
| dma_paddr | output | 32 | Forwarded address |
| dma_pspace | output | 4 | Parent space id for the forward |
| err_clr | input | 1 | Clear the error code |
| err_code | output | 3 | Sticky error: 0 none, 1 bad slot, 2 duplicate, 3 no window, 4 bad DMA space |

## Verification
Two pairs of functions can fall in the same cycle. The first is a configuration write together with an outbound or inbound lookup. The second is several error sources (bad slot, duplicate, empty enable, bad DMA space, plus err_clr) firing together. The bench provokes both pairs on purpose. It writes a new window and requests an address inside it on the same edge, then expects a miss that cycle and a hit on the next. It raises a configuration error and a DMA space error together, and a new error together with err_clr. A behavioural model of the table and the error register predicts every output, and the bench compares against that prediction after every edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    parameter int XL_AW    = 32;   // address and size width
    parameter int XL_PSW   = 4;    // parent space id width
    parameter int XL_NSLOT = 4;    // window slots
    localparam int SLOT_W    = $clog2(XL_NSLOT);
    localparam int CFGSLOT_W = SLOT_W + 1;

    typedef struct packed {
        logic [XL_AW-1:0]  pbase;
        logic [XL_AW-1:0]  cbase;
        logic [XL_PSW-1:0] pspace;
        logic [XL_AW-1:0]  size;
    } win_t;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_SLOT    = 3'd1,
        ERR_DUP     = 3'd2,
        ERR_NOWIN   = 3'd3,
        ERR_DMASPC  = 3'd4
    } err_e;

    function automatic logic [XL_AW:0] ext(input logic [XL_AW-1:0] a);
        return {1'b0, a};
    endfunction

    // window holds the whole access [addr, endx) and the access does not wrap
    function automatic logic win_holds(input win_t w,
                                       input logic [XL_AW-1:0] addr,
                                       input logic [XL_AW:0] endx);
        logic [XL_AW:0] top;
        logic [XL_AW:0] lim;
        top = ext(w.pbase) + ext(w.size);
        lim = {1'b1, {XL_AW{1'b0}}};
        return (w.size != '0) && (addr >= w.pbase) && (endx <= top) && (endx <= lim);
    endfunction

    function automatic logic in_closed(input logic [XL_AW:0] x,
                                       input logic [XL_AW:0] lo,
                                       input logic [XL_AW:0] hi);
        return (x >= lo) && (x <= hi);
    endfunction

endpackage

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_valid,
    input  logic                  cfg_clear,
    input  logic [CFGSLOT_W-1:0]  cfg_slot,
    input  win_t                  cfg_win,
    input  logic                  en_req,
    output win_t [XL_NSLOT-1:0]   win,
    output logic                  enabled,
    output err_e                  cfg_err,
    output logic                  en_err
);

    logic [XL_NSLOT-1:0] used;
    logic                any_used;
    logic                accept;
    logic                slot_ok;
    logic                dup;

    for (genvar g = 0; g < XL_NSLOT; g++) begin : g_used
        assign used[g] = (win[g].size != '0);
    end

    assign any_used = |used;
    assign accept   = cfg_valid && !cfg_clear;
    assign slot_ok  = (cfg_slot < CFGSLOT_W'(XL_NSLOT));
    assign dup      = slot_ok && used[cfg_slot[SLOT_W-1:0]];

    always_comb begin
        cfg_err = ERR_NONE;
        if (accept && !slot_ok)  cfg_err = ERR_SLOT;
        else if (accept && dup)  cfg_err = ERR_DUP;
    end

    assign en_err = en_req && !any_used;

    always_ff @(posedge clk) begin
        if (rst) begin
            win     <= '0;
            enabled <= 1'b0;
        end else if (cfg_clear) begin
            for (int i = 0; i < XL_NSLOT; i++) win[i].size <= '0;
            enabled <= 1'b0;
        end else begin
            if (accept && slot_ok && !dup) win[cfg_slot[SLOT_W-1:0]] <= cfg_win;
            if (en_req && any_used) enabled <= 1'b1;
        end
    end

    // R2: bad slot index leaves the table untouched
    a_r2_badslot_no_write: assert property (@(posedge clk) disable iff (rst)
        (accept && !slot_ok) |=> (win == $past(win)));

    // R3: a duplicate write leaves the table untouched
    a_r3_dup_no_write: assert property (@(posedge clk) disable iff (rst)
        (accept && dup) |=> (win == $past(win)));

    // R4: after a clear no slot is in use and translation is off
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |=> (used == '0 && !enabled));

    // R5: an empty-table enable never turns translation on
    a_r5_empty_enable: assert property (@(posedge clk) disable iff (rst)
        (en_req && !any_used && !enabled) |=> !enabled);

endmodule

// File: rtl/xlat_outbound.sv
module xlat_outbound
    import xlat_pkg::*;
#(
    parameter int NBW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  win_t [XL_NSLOT-1:0]  win,
    input  logic                 enabled,
    input  logic                 ob_valid,
    input  logic [XL_AW-1:0]     ob_addr,
    input  logic [NBW-1:0]       ob_nbytes,
    output logic                 ob_rsp_valid,
    output logic                 ob_hit,
    output logic [SLOT_W-1:0]    ob_slot,
    output logic [XL_PSW-1:0]    ob_pspace,
    output logic [XL_AW-1:0]     ob_caddr,
    output logic [NBW-1:0]       ob_count
);

    logic [XL_AW:0]       endx;
    logic [XL_NSLOT-1:0]  claim;
    logic [SLOT_W-1:0]    sel;
    logic                 hit;

    assign endx = ext(ob_addr) + {{(XL_AW+1-NBW){1'b0}}, ob_nbytes};

    for (genvar g = 0; g < XL_NSLOT; g++) begin : g_claim
        assign claim[g] = win_holds(win[g], ob_addr, endx);
    end

    always_comb begin
        sel = '0;
        for (int i = XL_NSLOT-1; i >= 0; i--) begin
            if (claim[i]) sel = SLOT_W'(i);
        end
    end

    assign hit = ob_valid && enabled && (|claim);

    always_ff @(posedge clk) begin
        if (rst) begin
            ob_rsp_valid <= 1'b0;
            ob_hit       <= 1'b0;
            ob_slot      <= '0;
            ob_pspace    <= '0;
            ob_caddr     <= '0;
            ob_count     <= '0;
        end else begin
            ob_rsp_valid <= ob_valid;
            ob_hit       <= hit;
            ob_slot      <= hit ? sel : '0;
            ob_pspace    <= hit ? win[sel].pspace : '0;
            ob_caddr     <= hit ? (ob_addr - win[sel].pbase + win[sel].cbase) : '0;
            ob_count     <= hit ? ob_nbytes : '0;
        end
    end

    // R6: every request gets its result on the next cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ob_valid |=> ob_rsp_valid);

    // R8: a miss moves no bytes
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (ob_rsp_valid && !ob_hit) |-> (ob_count == '0));

    // R6: nothing is claimed while translation is off
    a_r6_off_no_hit: assert property (@(posedge clk) disable iff (rst)
        (ob_valid && !enabled) |=> !ob_hit);

endmodule

// File: rtl/xlat_inbound.sv
module xlat_inbound
    import xlat_pkg::*;
#(
    parameter int NBW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [XL_AW-1:0]     mem_cbase,
    input  logic [XL_AW-1:0]     mem_size,
    input  logic [XL_PSW-1:0]    mem_pspace,
    input  logic                 dma_valid,
    input  logic [SLOT_W-1:0]    dma_space,
    input  logic [XL_AW-1:0]     dma_addr,
    input  logic [NBW-1:0]       dma_nbytes,
    output logic                 dma_rsp_valid,
    output logic                 dma_fwd,
    output logic                 dma_reject,
    output logic [XL_AW-1:0]     dma_paddr,
    output logic [XL_PSW-1:0]    dma_pspace,
    output logic                 dma_err
);

    logic [XL_AW:0] lo, hi, s, e;
    logic           mem_ok, own, fwd;

    assign lo     = ext(mem_cbase);
    assign hi     = ext(mem_cbase) + ext(mem_size);
    assign s      = ext(dma_addr);
    assign e      = ext(dma_addr) + {{(XL_AW+1-NBW){1'b0}}, dma_nbytes};
    assign mem_ok = (dma_space == '0);
    assign own    = in_closed(s, lo, hi) || in_closed(e, lo, hi);
    assign fwd    = dma_valid && mem_ok && !own;
    assign dma_err = dma_valid && !mem_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_rsp_valid <= 1'b0;
            dma_fwd       <= 1'b0;
            dma_reject    <= 1'b0;
            dma_paddr     <= '0;
            dma_pspace    <= '0;
        end else begin
            dma_rsp_valid <= dma_valid;
            dma_fwd       <= fwd;
            dma_reject    <= dma_valid && mem_ok && own;
            dma_paddr     <= fwd ? dma_addr : '0;
            dma_pspace    <= fwd ? mem_pspace : '0;
        end
    end

    // R10: forward and refuse never both
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_fwd, dma_reject}));

    // R9: a non-memory space is neither forwarded nor refused
    a_r9_bad_space: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && dma_space != '0) |=> (!dma_fwd && !dma_reject));

    // R11: the forwarded address is the requested one
    a_r11_addr_kept: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && dma_space == '0) |=> (!dma_fwd || dma_paddr == $past(dma_addr)));

endmodule

// File: rtl/bridge_xlat.sv
module bridge_xlat
    import xlat_pkg::*;
#(
    parameter int NBW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_valid,
    output logic                  cfg_ready,
    input  logic                  cfg_clear,
    input  logic [CFGSLOT_W-1:0]  cfg_slot,
    input  logic [XL_AW-1:0]      cfg_pbase,
    input  logic [XL_PSW-1:0]     cfg_pspace,
    input  logic [XL_AW-1:0]      cfg_cbase,
    input  logic [XL_AW-1:0]      cfg_size,
    input  logic                  en_req,
    output logic                  enabled,
    input  logic                  ob_valid,
    input  logic [XL_AW-1:0]      ob_addr,
    input  logic [NBW-1:0]        ob_nbytes,
    output logic                  ob_rsp_valid,
    output logic                  ob_hit,
    output logic [SLOT_W-1:0]     ob_slot,
    output logic [XL_PSW-1:0]     ob_pspace,
    output logic [XL_AW-1:0]      ob_caddr,
    output logic [NBW-1:0]        ob_count,
    input  logic                  dma_valid,
    input  logic [SLOT_W-1:0]     dma_space,
    input  logic [XL_AW-1:0]      dma_addr,
    input  logic [NBW-1:0]        dma_nbytes,
    output logic                  dma_rsp_valid,
    output logic                  dma_fwd,
    output logic                  dma_reject,
    output logic [XL_AW-1:0]      dma_paddr,
    output logic [XL_PSW-1:0]     dma_pspace,
    input  logic                  err_clr,
    output logic [2:0]            err_code
);

    win_t                 cfg_w;
    win_t [XL_NSLOT-1:0]  win;
    err_e                 cfg_err;
    logic                 en_err;
    logic                 dma_err;
    err_e                 cand, base, err_q;

    assign cfg_w     = '{pbase: cfg_pbase, cbase: cfg_cbase, pspace: cfg_pspace, size: cfg_size};
    assign cfg_ready = !cfg_clear;

    xlat_table u_table (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_clear(cfg_clear), .cfg_slot(cfg_slot), .cfg_win(cfg_w),
        .en_req(en_req), .win(win), .enabled(enabled),
        .cfg_err(cfg_err), .en_err(en_err)
    );

    xlat_outbound #(.NBW(NBW)) u_out (
        .clk(clk), .rst(rst), .win(win), .enabled(enabled),
        .ob_valid(ob_valid), .ob_addr(ob_addr), .ob_nbytes(ob_nbytes),
        .ob_rsp_valid(ob_rsp_valid), .ob_hit(ob_hit), .ob_slot(ob_slot),
        .ob_pspace(ob_pspace), .ob_caddr(ob_caddr), .ob_count(ob_count)
    );

    xlat_inbound #(.NBW(NBW)) u_in (
        .clk(clk), .rst(rst),
        .mem_cbase(win[0].cbase), .mem_size(win[0].size), .mem_pspace(win[0].pspace),
        .dma_valid(dma_valid), .dma_space(dma_space), .dma_addr(dma_addr), .dma_nbytes(dma_nbytes),
        .dma_rsp_valid(dma_rsp_valid), .dma_fwd(dma_fwd), .dma_reject(dma_reject),
        .dma_paddr(dma_paddr), .dma_pspace(dma_pspace), .dma_err(dma_err)
    );

    always_comb begin
        if (cfg_err != ERR_NONE) cand = cfg_err;
        else if (en_err)         cand = ERR_NOWIN;
        else if (dma_err)        cand = ERR_DMASPC;
        else                     cand = ERR_NONE;
        base = err_clr ? ERR_NONE : err_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                    err_q <= ERR_NONE;
        else if (base == ERR_NONE)  err_q <= cand;
        else                        err_q <= base;
    end

    assign err_code = err_q;

    // R12: a recorded error stays until cleared
    a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_code != 3'd0 && !err_clr) |=> $stable(err_code));

    // R9: a bad DMA space always leaves an error behind
    a_r9_err_seen: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && dma_space != '0) |=> (err_code != 3'd0));

endmodule

// File: tb/bridge_xlat_bench.sv
`timescale 1ns/1ps
module bridge_xlat_bench;

    localparam int NBW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 0, cfg_clear = 0, en_req = 0, err_clr = 0;
    logic [2:0]  cfg_slot = 0;
    logic [31:0] cfg_pbase = 0, cfg_cbase = 0, cfg_size = 0;
    logic [3:0]  cfg_pspace = 0;
    logic        ob_valid = 0;
    logic [31:0] ob_addr = 0;
    logic [15:0] ob_nbytes = 0;
    logic        dma_valid = 0;
    logic [1:0]  dma_space = 0;
    logic [31:0] dma_addr = 0;
    logic [15:0] dma_nbytes = 0;

    logic        cfg_ready, enabled;
    logic        ob_rsp_valid, ob_hit;
    logic [1:0]  ob_slot;
    logic [3:0]  ob_pspace;
    logic [31:0] ob_caddr;
    logic [15:0] ob_count;
    logic        dma_rsp_valid, dma_fwd, dma_reject;
    logic [31:0] dma_paddr;
    logic [3:0]  dma_pspace;
    logic [2:0]  err_code;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    bridge_xlat #(.NBW(NBW)) u_bridge_xlat (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_clear(cfg_clear), .cfg_slot(cfg_slot),
        .cfg_pbase(cfg_pbase), .cfg_pspace(cfg_pspace), .cfg_cbase(cfg_cbase), .cfg_size(cfg_size),
        .en_req(en_req), .enabled(enabled),
        .ob_valid(ob_valid), .ob_addr(ob_addr), .ob_nbytes(ob_nbytes),
        .ob_rsp_valid(ob_rsp_valid), .ob_hit(ob_hit), .ob_slot(ob_slot), .ob_pspace(ob_pspace),
        .ob_caddr(ob_caddr), .ob_count(ob_count),
        .dma_valid(dma_valid), .dma_space(dma_space), .dma_addr(dma_addr), .dma_nbytes(dma_nbytes),
        .dma_rsp_valid(dma_rsp_valid), .dma_fwd(dma_fwd), .dma_reject(dma_reject),
        .dma_paddr(dma_paddr), .dma_pspace(dma_pspace),
        .err_clr(err_clr), .err_code(err_code)
    );

    // behavioural reference state
    logic [31:0] m_pb [4];
    logic [31:0] m_cb [4];
    logic [3:0]  m_ps [4];
    logic [31:0] m_sz [4];
    bit          m_en;
    int          m_err;

    task automatic chk(input string tag, input string what, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] s, input logic [31:0] pb, input logic [3:0] ps,
                           input logic [31:0] cb, input logic [31:0] sz);
        cfg_valid = 1; cfg_slot = s; cfg_pbase = pb; cfg_pspace = ps; cfg_cbase = cb; cfg_size = sz;
    endtask

    task automatic set_ob(input logic [31:0] a, input logic [15:0] n);
        ob_valid = 1; ob_addr = a; ob_nbytes = n;
    endtask

    task automatic set_dma(input logic [1:0] sp, input logic [31:0] a, input logic [15:0] n);
        dma_valid = 1; dma_space = sp; dma_addr = a; dma_nbytes = n;
    endtask

    task automatic tick(input string tag);
        longint unsigned ee, se, lo, hi;
        longint unsigned lim = 64'h1_0000_0000;
        int   sel = -1;
        bit   any_used = 0;
        bit   accept, rej;
        int   c, base;
        logic [127:0] x_ob, x_dma;
        logic [31:0]  ca;

        for (int i = 0; i < 4; i++) if (m_sz[i] != 0) any_used = 1;
        accept = cfg_valid && !cfg_clear;

        // outbound prediction
        ee = longint'(ob_addr) + longint'(ob_nbytes);
        if (ob_valid && m_en)
            for (int i = 0; i < 4; i++)
                if (sel < 0 && m_sz[i] != 0 && ob_addr >= m_pb[i] &&
                    ee <= longint'(m_pb[i]) + longint'(m_sz[i]) && ee <= lim) sel = i;
        if (sel >= 0) begin
            ca = ob_addr - m_pb[sel] + m_cb[sel];
            x_ob = {1'b1, 1'b1, 2'(sel), m_ps[sel], ca, ob_nbytes};
        end else begin
            x_ob = {ob_valid, 1'b0, 2'd0, 4'd0, 32'd0, 16'd0};
        end

        // inbound prediction
        x_dma = {dma_valid, 1'b0, 1'b0, 32'd0, 4'd0};
        if (dma_valid && dma_space == 0) begin
            lo = longint'(m_cb[0]);
            hi = lo + longint'(m_sz[0]);
            se = longint'(dma_addr);
            ee = se + longint'(dma_nbytes);
            rej = (se >= lo && se <= hi) || (ee >= lo && ee <= hi);
            if (rej) x_dma = {1'b1, 1'b0, 1'b1, 32'd0, 4'd0};
            else     x_dma = {1'b1, 1'b1, 1'b0, dma_addr, m_ps[0]};
        end

        // error prediction
        c = 0;
        if (accept && cfg_slot > 3)                 c = 1;
        else if (accept && m_sz[cfg_slot[1:0]] != 0) c = 2;
        else if (en_req && !any_used)               c = 3;
        else if (dma_valid && dma_space != 0)       c = 4;
        base  = err_clr ? 0 : m_err;
        m_err = (base == 0) ? c : base;

        // table prediction
        if (cfg_clear) begin
            for (int i = 0; i < 4; i++) m_sz[i] = 0;
            m_en = 0;
        end else begin
            if (accept && cfg_slot <= 3 && m_sz[cfg_slot[1:0]] == 0) begin
                m_pb[cfg_slot[1:0]] = cfg_pbase;
                m_cb[cfg_slot[1:0]] = cfg_cbase;
                m_ps[cfg_slot[1:0]] = cfg_pspace;
                m_sz[cfg_slot[1:0]] = cfg_size;
            end
            if (en_req && any_used) m_en = 1;
        end

        @(posedge clk);
        @(negedge clk);

        chk(tag, "outbound", {ob_rsp_valid, ob_hit, ob_slot, ob_pspace, ob_caddr, ob_count}, x_ob);
        chk(tag, "inbound", {dma_rsp_valid, dma_fwd, dma_reject, dma_paddr, dma_pspace}, x_dma);
        chk(tag, "err_code", 128'(err_code), 128'(m_err));
        chk(tag, "enabled", 128'(enabled), 128'(m_en));

        cfg_valid = 0; cfg_clear = 0; en_req = 0; err_clr = 0; ob_valid = 0; dma_valid = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : stimulus
        for (int i = 0; i < 4; i++) begin m_pb[i] = 0; m_cb[i] = 0; m_ps[i] = 0; m_sz[i] = 0; end
        m_en = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        tick("R5 reset state");                              // R12 error clear at reset too
        en_req = 1; tick("R5 enable with empty table");
        err_clr = 1; tick("R12 clear");
        set_ob(32'h8000_0000, 4); tick("R6 off before enable");

        set_cfg(0, 32'h8000_0000, 4'h1, 32'h8000_0000, 32'h1000_0000); tick("R1 load memory slot");
        set_cfg(1, 32'hC000_0000, 4'h2, 32'h0000_0000, 32'h0001_0000); tick("R1 load io slot");
        set_cfg(5, 32'h1, 4'h3, 32'h1, 32'h10); tick("R2 slot out of range");
        err_clr = 1; tick("R12 clear");
        set_cfg(0, 32'h0, 4'h7, 32'h0, 32'h10); tick("R3 duplicate");
        err_clr = 1; en_req = 1; tick("R5 enable");

        set_ob(32'hC000_0010, 4);  tick("R7 io translation");
        set_ob(32'h8000_1000, 8);  tick("R7 memory unchanged after duplicate");
        set_ob(32'hC000_FFFC, 4);  tick("R6 access ends at window top");
        set_ob(32'hC000_FFFC, 5);  tick("R8 access crosses window top");
        set_ob(32'h0000_1234, 2);  tick("R8 no window");

        set_cfg(2, 32'hC000_0000, 4'h5, 32'h0000_0500, 32'h100); tick("R1 load config slot");
        set_ob(32'hC000_0000, 4);  tick("R6 lowest slot wins");
        set_cfg(3, 32'hFFFF_F000, 4'h6, 32'h0, 32'h2000); tick("R1 load special slot");
        set_ob(32'hFFFF_FFFE, 4);  tick("R8 wrap past top");
        set_ob(32'hFFFF_FFFC, 4);  tick("R6 end exactly at top");
        set_ob(32'hFFFF_F010, 16); tick("R7 special translation");

        set_dma(0, 32'h0000_1000, 16); tick("R11 forward");
        set_dma(0, 32'h7FFF_FFF0, 16); tick("R10 end on low bound");
        set_dma(0, 32'h9000_0000, 4);  tick("R10 start on high bound");
        set_dma(0, 32'h9000_0001, 4);  tick("R11 just above window");
        set_dma(0, 32'h7FFF_FFEF, 16); tick("R11 just below window");
        set_dma(1, 32'h0000_1000, 4);  tick("R9 io space dma");
        err_clr = 1; tick("R12 clear");

        set_cfg(6, 32'h0, 0, 32'h0, 32'h4); set_dma(2, 32'h100, 4); tick("R12 cfg error beats dma error");
        err_clr = 1; set_dma(3, 32'h200, 4); tick("R12 clear with new error");
        err_clr = 1; tick("R12 clear");

        cfg_clear = 1; set_cfg(1, 32'h4000_0000, 4'h9, 32'h0, 32'h100); tick("R4 clear beats write");
        set_ob(32'h8000_0000, 4); tick("R4 no claim after clear");
        set_cfg(1, 32'h4000_0000, 4'h9, 32'h0, 32'h100); en_req = 1; tick("R5 enable judged on old table");
        err_clr = 1; tick("R12 clear");
        en_req = 1; tick("R5 enable");
        set_cfg(0, 32'h5000_0000, 4'hA, 32'h0010_0000, 32'h1000);
        set_ob(32'h5000_0010, 4); set_dma(0, 32'h0010_0000, 4); tick("R13 lookup sees old table");
        set_ob(32'h5000_0010, 4); set_dma(0, 32'h0010_0000, 4); tick("R13 next cycle sees new window");
        set_ob(32'h4000_00FC, 4); tick("R7 reloaded io slot");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule